// File: doc/BRIEF.md
# Line Burst Read Sequencer

This block is a bus master that fetches one 16-byte line, as four 32-bit long words, to fill a cache line or to serve a 16-byte block move. The start address may point at any long word of the line. The block first tries a single-address burst. During the burst it holds the address and the attributes steady while the slave returns one long word per acknowledged beat. The words arrive in wrap order: they start at the requested word and step through address bits 3:2 modulo four.

The slave may not be able to burst. It shows this by raising the burst-inhibit input together with the first acknowledge. The block then ends the burst after that word and fetches the other three words with separate single reads, in the same wrap order. Each captured word appears on the output with its index inside the line. A one-clock pulse marks the end of the line.

Top module: `lineBurstMaster`

## Requirements
- R1: A synchronous active-high reset brings the block to idle. After reset, busStart, busInProg, wordValid and lineDone are low and reqReady is high.
- R2: A request is taken only on a rising edge where reqReady is high. In the cycle after that edge, busStart is high. While a line is in flight, reqValid and reqAddr are ignored.
- R3: busStart is high for exactly one clock at the start of each bus cycle. A plain line has one such cycle. A line that falls back to single reads has four (the burst plus three singles).
- R4: In burst mode (busBurst = 1), busAddr[31:4] is the line base, busAddr[3:2] is the start index and busAddr[1:0] is 0. busAttr equals the request attributes. Both hold steady for all beats of the burst.
- R5: The acknowledge input is not sampled in the start cycle. In a data cycle without acknowledge, the data bus is ignored and the block waits with no limit.
- R6: On a rising edge where acknowledge is sampled high in a data cycle, the data bus is captured. In the next cycle, wordValid is high and wordData holds the captured value.
- R7: wordIndex counts up from the start index (address bits 3:2) and wraps modulo four.
- R8: If burst-inhibit is high together with the first burst acknowledge, the remaining three words are read as single cycles with busBurst = 0 and busAddr[3:2] set to the index of the word being read. Burst-inhibit is ignored on every other beat.
- R9: busInProg is high from the first start cycle through the cycle of the final acknowledge, and stays high between the fallback single reads. It is low in the cycle after the final acknowledge.
- R10: lineDone is a one-clock pulse in the same cycle as the fourth wordValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Line fetch request |
| reqAddr | input | 32 | Request byte address; bits 3:2 pick the first word |
| reqAttr | input | 4 | Transfer attributes for the line |
| reqReady | output | 1 | Block is idle and can take a request |
| busStart | output | 1 | One-clock transfer-start strobe |
| busAddr | output | 32 | Bus address |
| busAttr | output | 4 | Bus transfer attributes |
| busBurst | output | 1 | 1 for a line burst, 0 for a single long-word read |
| busInProg | output | 1 | Transfer in progress |
| busAck | input | 1 | Transfer acknowledge from the slave |
| busBurstInh | input | 1 | Burst inhibit from the slave |
| busData | input | 32 | Read data bus |
| wordValid | output | 1 | Captured word is valid this cycle |
| wordIndex | output | 2 | Index of the captured word within the line |
| wordData | output | 32 | Captured word |
| lineDone | output | 1 | Pulse: the fourth word was captured |

## Verification
A request sampled on one rising edge shows busStart in the next cycle. An acknowledge sampled on a data-cycle edge shows wordValid, wordIndex and wordData in the cycle after that edge. The fourth such edge also drops busInProg and raises lineDone in that same following cycle. The bench drives every input on the falling edge and reads the outputs on the next falling edge, so each check falls exactly one register stage after its stimulus. The sweep covers every start index, with and without first-beat inhibit, with late inhibit, and with several wait-state patterns. In every one of these runs the bench keeps a junk request and acknowledges during start cycles present, and checks that they are ignored.

// File: rtl/lbmPkg.sv
package lbmPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} lbmState_e;

  typedef struct packed {
    logic load;      // take request fields into the datapath
    logic capture;   // acknowledged beat: latch data and advance pointer
    logic burstMode; // address uses the start index
    logic active;    // a bus cycle is in flight
  } lbmStrobes_t;
endpackage

// File: rtl/lbmControl.sv
module lbmControl
  import lbmPkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        busAck,
  input  logic        busBurstInh,
  output lbmStrobes_t strobes,
  output logic        reqReady,
  output logic        busStart,
  output logic        busInProg,
  output logic        busBurst,
  output logic        lineDone
);
  localparam logic [IDX_W-1:0] LAST_BEAT = '1;
  localparam logic [IDX_W-1:0] FIRST_BEAT = '0;

  lbmState_e        state;
  logic [IDX_W-1:0] beatCnt;
  logic             burstMode;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      beatCnt   <= '0;
      burstMode <= 1'b0;
      lineDone  <= 1'b0;
    end else begin
      lineDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state     <= ST_ADDR;
            burstMode <= 1'b1;
            beatCnt   <= '0;
          end
        end
        ST_ADDR: state <= ST_DATA;
        ST_DATA: begin
          if (busAck) begin
            beatCnt <= beatCnt + 1'b1;
            if (beatCnt == LAST_BEAT) begin
              state     <= ST_IDLE;
              lineDone  <= 1'b1;
              burstMode <= 1'b0;
            end else if (!burstMode) begin
              state <= ST_ADDR;
            end else if (beatCnt == FIRST_BEAT && busBurstInh) begin
              burstMode <= 1'b0;
              state     <= ST_ADDR;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.load      = (state == ST_IDLE) && reqValid;
    strobes.capture   = (state == ST_DATA) && busAck;
    strobes.burstMode = burstMode;
    strobes.active    = (state != ST_IDLE);
    reqReady          = (state == ST_IDLE);
    busStart          = (state == ST_ADDR);
    busInProg         = (state != ST_IDLE);
    busBurst          = burstMode;
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    busStart |=> !busStart); // R3
  AST_TIP_RISES_WITH_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busInProg) |-> busStart); // R9
  AST_DONE_CLOSES_LINE: assert property (@(posedge clk) disable iff (rst)
    lineDone |-> (!busInProg && $past(busInProg))); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    busInProg |-> !reqReady); // R2
endmodule

// File: rtl/lbmDatapath.sv
module lbmDatapath
  import lbmPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ATTR_W = 4,
  parameter int IDX_W  = 2,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  lbmStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ATTR_W-1:0] reqAttr,
  input  logic [DATA_W-1:0] busData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ATTR_W-1:0] busAttr,
  output logic              wordValid,
  output logic [IDX_W-1:0]  wordIndex,
  output logic [DATA_W-1:0] wordData
);
  localparam int LINE_LSB = IDX_W + OFS_W;

  logic [ADDR_W-1:LINE_LSB] lineBase;
  logic [IDX_W-1:0]         startIdx;
  logic [IDX_W-1:0]         wordPtr;
  logic [ATTR_W-1:0]        attrReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      lineBase  <= '0;
      startIdx  <= '0;
      wordPtr   <= '0;
      attrReg   <= '0;
      wordValid <= 1'b0;
      wordIndex <= '0;
      wordData  <= '0;
    end else begin
      wordValid <= 1'b0;
      if (strobes.load) begin
        lineBase <= reqAddr[ADDR_W-1:LINE_LSB];
        startIdx <= reqAddr[LINE_LSB-1:OFS_W];
        wordPtr  <= reqAddr[LINE_LSB-1:OFS_W];
        attrReg  <= reqAttr;
      end
      if (strobes.capture) begin
        wordPtr   <= wordPtr + 1'b1;
        wordIndex <= wordPtr;
        wordData  <= busData;
        wordValid <= 1'b1;
      end
    end
  end

  assign busAddr = {lineBase, (strobes.burstMode ? startIdx : wordPtr), {OFS_W{1'b0}}};
  assign busAttr = attrReg;

  AST_BURST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (strobes.burstMode && strobes.active && $past(strobes.burstMode && strobes.active))
      |-> ($stable(busAddr) && $stable(busAttr))); // R4
  AST_WORD_FROM_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> $past(strobes.capture)); // R6
  AST_INDEX_STEPS: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && wordValid) |=> (wordIndex == $past(wordIndex) + 1'b1)); // R7
endmodule

// File: rtl/lineBurstMaster.sv
module lineBurstMaster
  import lbmPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ATTR_W     = 4,
  parameter int LINE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ATTR_W-1:0] reqAttr,
  output logic              reqReady,
  output logic              busStart,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ATTR_W-1:0] busAttr,
  output logic              busBurst,
  output logic              busInProg,
  input  logic              busAck,
  input  logic              busBurstInh,
  input  logic [DATA_W-1:0] busData,
  output logic              wordValid,
  output logic [$clog2(LINE_BYTES/(DATA_W/8))-1:0] wordIndex,
  output logic [DATA_W-1:0] wordData,
  output logic              lineDone
);
  localparam int BYTES_PER_WORD = DATA_W / 8;
  localparam int WORDS          = LINE_BYTES / BYTES_PER_WORD;
  localparam int IDX_W          = $clog2(WORDS);
  localparam int OFS_W          = $clog2(BYTES_PER_WORD);

  lbmStrobes_t strobes;

  lbmControl #(.IDX_W(IDX_W)) uCtl (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .busAck     (busAck),
    .busBurstInh(busBurstInh),
    .strobes    (strobes),
    .reqReady   (reqReady),
    .busStart   (busStart),
    .busInProg  (busInProg),
    .busBurst   (busBurst),
    .lineDone   (lineDone)
  );

  lbmDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ATTR_W(ATTR_W),
    .IDX_W (IDX_W),  .OFS_W (OFS_W)
  ) uDp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqAttr  (reqAttr),
    .busData  (busData),
    .busAddr  (busAddr),
    .busAttr  (busAttr),
    .wordValid(wordValid),
    .wordIndex(wordIndex),
    .wordData (wordData)
  );
endmodule

// File: tb/tb_lineBurstMaster.sv
`timescale 1ns/1ps
module tb_lineBurstMaster;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqAttr = '0;
  logic        reqReady, busStart, busBurst, busInProg;
  logic [31:0] busAddr;
  logic [3:0]  busAttr;
  logic        busAck = 1'b0;
  logic        busBurstInh = 1'b0;
  logic [31:0] busData = '0;
  logic        wordValid, lineDone;
  logic [1:0]  wordIndex;
  logic [31:0] wordData;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lineBurstMaster dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr), .reqAttr(reqAttr),
    .reqReady(reqReady), .busStart(busStart), .busAddr(busAddr), .busAttr(busAttr),
    .busBurst(busBurst), .busInProg(busInProg), .busAck(busAck),
    .busBurstInh(busBurstInh), .busData(busData), .wordValid(wordValid),
    .wordIndex(wordIndex), .wordData(wordData), .lineDone(lineDone)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expData(input logic [31:0] base, input int idx);
    return (base ^ 32'hC0DE_0000) + idx * 32'h0001_1111;
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runLine(input int lineNo, input int st, input bit inhFirst,
                         input bit inhLate, input int seed);
    logic [31:0] base;
    logic [31:0] expAddr;
    bit burst;
    int idx;
    int waits;
    base  = 32'h1000_0000 + lineNo * 64;
    burst = 1'b1;
    chk("R2 ready before request", reqReady, 1);
    reqValid = 1'b1;
    reqAddr  = base | (st << 2) | 32'h3;
    reqAttr  = lineNo[3:0];
    cyc();
    // R2: keep a junk request asserted while busy
    reqAddr = 32'hDEAD_BEEC;
    reqAttr = ~lineNo[3:0];
    chk("R3 start strobe", busStart, 1);
    chk("R9 tip at start", busInProg, 1);
    chk("R4 burst address", busAddr, base | (st << 2));
    chk("R4 burst flag", busBurst, 1);
    chk("R4 attributes", busAttr, {28'd0, lineNo[3:0]});
    // R5: acknowledge in the start cycle must be ignored
    busAck = 1'b1; busData = 32'hBAD0_0000;
    cyc();
    busAck = 1'b0;
    chk("R5 no capture in start cycle", wordValid, 0);
    chk("R3 start ends", busStart, 0);
    for (int k = 0; k < 4; k++) begin
      idx     = (st + k) % 4;
      waits   = (seed + k) % 3;
      expAddr = burst ? (base | (st << 2)) : (base | (idx << 2));
      for (int w = 0; w < waits; w++) begin
        busAck = 1'b0; busBurstInh = 1'b1; busData = 32'hBAD0_0001 + w;
        cyc();
        chk("R5 wait no word", wordValid, 0);
        chk("R3 no start in wait", busStart, 0);
        chk("R9 tip in wait", busInProg, 1);
        chk(burst ? "R4 stable address" : "R8 single address", busAddr, expAddr);
      end
      busAck = 1'b1;
      busData = expData(base, idx);
      busBurstInh = (k == 0) ? inhFirst : inhLate;
      if (k == 3) reqValid = 1'b0;
      cyc();
      busAck = 1'b0; busBurstInh = 1'b0;
      chk("R6 word valid", wordValid, 1);
      chk("R6 word data", wordData, expData(base, idx));
      chk("R7 word index", wordIndex, idx);
      chk("R10 line done", lineDone, (k == 3));
      chk("R9 tip after beat", busInProg, (k < 3));
      if (k == 0 && inhFirst) burst = 1'b0;
      if (k < 3) begin
        if (!burst) begin
          chk("R8 single start", busStart, 1);
          chk("R8 single flag", busBurst, 0);
          chk("R8 single address", busAddr, base | (((st + k + 1) % 4) << 2));
          busAck = 1'b1; busData = 32'hBAD0_0002;
          cyc();
          busAck = 1'b0;
          chk("R5 single start ignores ack", wordValid, 0);
        end else begin
          chk("R3 no restart in burst", busStart, 0);
          chk("R8 late inhibit ignored", busBurst, 1);
        end
      end
    end
    chk("R2 ready after line", reqReady, 1);
    chk("R2 no hidden request", busStart, 0);
    cyc();
    chk("R2 still idle", busStart, 0);
    chk("R10 done one pulse", lineDone, 0);
    chk("R6 word pulse ends", wordValid, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int lineNo;
    lineNo = 0;
    @(negedge clk);
    cyc();
    cyc();
    rst = 1'b0;
    chk("R1 reset start", busStart, 0);
    chk("R1 reset tip", busInProg, 0);
    chk("R1 reset word", wordValid, 0);
    chk("R1 reset done", lineDone, 0);
    chk("R1 reset ready", reqReady, 1);
    for (int st = 0; st < 4; st++)
      for (int inh = 0; inh < 2; inh++)
        for (int late = 0; late < 2; late++)
          for (int seed = 0; seed < 3; seed++) begin
            runLine(lineNo, st, inh[0], late[0], seed);
            lineNo++;
          end
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule